// File: doc/BRIEF.md
# ISA-to-PCI Single-Cycle Memory Master Bridge

This block accepts memory cycles that an ISA bus master or a DMA channel starts on the ISA side and turns them into PCI memory transactions of exactly one data phase. A fixed legacy memory map decides where each cycle goes. It covers the conventional memory area, the video buffer, an expansion ROM window of eight 16 KB sections, the lower BIOS area, and a window of ISA memory above 1 MB whose top is programmable. If the target is on PCI, the bridge stretches the ISA cycle with its ready output, runs the PCI transaction and returns read data to the ISA side. If the target stays on ISA, the bridge does nothing.

The ISA strobes are taken as synchronous to the PCI clock by default. A parameter can insert a synchronizer instead. The bridge drives the PCI address/data, byte enables and parity only while its bus grant input is high. Three configuration bytes hold the forwarding enables and the ISA memory top.

Top module: `isa_pci_membridge`

## Requirements
- R1: After reset, FRAME# and IRDY# are high, every PCI driver enable is low and the ISA ready output is high.
- R2: Below 1 MB, config byte 0 enables forwarding: bit0 covers 0–512 KB, bit1 512–640 KB, bit2 640–768 KB and bit3 896–960 KB. The range 960 KB–1 MB is always forwarded.
- R3: The range 768–896 KB is forwarded per 16 KB section. Config byte 2 bit k enables the section that starts at 768 KB + 16 KB·k.
- R4: Let T be config byte 1 bits [3:0]. An address whose bits [23:20] lie in 1..T stays on ISA. Any other address of 1 MB or more is forwarded. T=0 forwards all of it.
- R5: A strobe to a non-forwarded address starts no PCI cycle, and the ISA ready output stays high.
- R6: A forwarded strobe with grant high starts the address phase at the next clock edge. The bridge drives FRAME# low, AD = {8'h00, A[23:2], 2'b00} and C/BE# = 0110 for a read or 0111 for a write.
- R7: FRAME# stays low for exactly two clocks. IRDY# goes low in the second clock and stays low until the data phase ends.
- R8: In the data phase, C/BE# is active low. A1 selects the lanes: A1=0 selects lanes 1:0 and A1=1 selects lanes 3:2. The lower lane of the pair is enabled when A0=0, and the upper lane when SBHE#=0. Write data goes on AD[15:0] or AD[31:16] according to A1. On a read the bridge releases AD after the address phase.
- R9: PAR is even parity over the AD and C/BE# values of the previous clock. The PAR enable follows the AD enable of the previous clock.
- R10: The ISA ready output is low from a forwarded strobe until the edge that samples TRDY# low. Read data from the half selected by A1 is captured at that edge and held.
- R11: The cycle ends as a master abort at the fifth edge after the address phase if DEVSEL# was low at none of those five edges. The ISA cycle is then released with read data FFFFh. DEVSEL# low at the fifth edge prevents the abort.
- R12: While grant is low, no cycle starts, the ISA ready output stays low for a forwarded strobe, and all PCI driver enables are forced low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 2 | Configuration byte select (0 low regions, 1 ISA top, 2 ROM sections) |
| cfg_wdata | input | 8 | Configuration write data |
| isa_memr_n | input | 1 | ISA memory read strobe, active low |
| isa_memw_n | input | 1 | ISA memory write strobe, active low |
| isa_sbhe_n | input | 1 | ISA byte-high enable, active low |
| isa_addr | input | 24 | ISA address |
| isa_wdata | input | 16 | ISA write data |
| isa_rdata | output | 16 | Read data returned to ISA |
| isa_rdy | output | 1 | ISA ready; low stretches the cycle |
| pci_gnt | input | 1 | PCI bus grant |
| pci_ad_out | output | 32 | AD value driven |
| pci_ad_in | input | 32 | AD value received |
| pci_ad_oe | output | 1 | AD driver enable |
| pci_cbe_n | output | 4 | Command / byte enables |
| pci_cbe_oe | output | 1 | C/BE# driver enable |
| pci_par | output | 1 | Parity |
| pci_par_oe | output | 1 | Parity driver enable |
| pci_frame_n | output | 1 | FRAME# |
| pci_irdy_n | output | 1 | IRDY# |
| pci_trdy_n | input | 1 | TRDY# from target |
| pci_devsel_n | input | 1 | DEVSEL# from target |

## Verification
The hardest case to reach from the ports is the master-abort boundary. DEVSEL# must stay high through exactly four sampling edges, and the outcome then depends on the fifth edge alone. The bench holds the target silent and counts falling clock edges from the strobe. In one run DEVSEL# never appears and the bench checks IRDY# and the returned all-ones data on either side of the fifth edge. In a second run DEVSEL# appears exactly at the fifth edge and the bench checks that the cycle continues to a normal TRDY# completion. The bench also drops grant in the middle of a data phase to check that the drivers release at once.

// File: rtl/ipb_pkg.sv
`timescale 1ns/1ps
package ipb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_APH,
      ST_DPH1,
      ST_DPHW,
      ST_HOLD
   } mst_state_e;

   localparam logic [3:0] CMD_MEM_RD = 4'b0110;
   localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/ipb_cfg_bank.sv
`timescale 1ns/1ps
module ipb_cfg_bank #(
   parameter int ROM_SECTIONS = 8,
   parameter int TOP_W        = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [1:0]              cfg_sel,
   input  logic [7:0]              cfg_wdata,
   output logic [3:0]              low_en,
   output logic [TOP_W-1:0]        isa_top,
   output logic [ROM_SECTIONS-1:0] rom_en
);
   if (ROM_SECTIONS > 8) begin : g_bad_rom
      $error("ROM_SECTIONS must fit in one configuration byte");
   end
   if (TOP_W > 8) begin : g_bad_top
      $error("TOP_W must fit in one configuration byte");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_en  <= '0;
         isa_top <= '0;
         rom_en  <= '0;
      end else if (cfg_we) begin
         case (cfg_sel)
            2'd0:    low_en  <= cfg_wdata[3:0];
            2'd1:    isa_top <= cfg_wdata[TOP_W-1:0];
            2'd2:    rom_en  <= cfg_wdata[ROM_SECTIONS-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ipb_region_dec.sv
`timescale 1ns/1ps
module ipb_region_dec #(
   parameter int ADDR_W       = 24,
   parameter int ROM_SECTIONS = 8
) (
   input  logic [ADDR_W-1:0]       addr,
   input  logic [3:0]              low_en,
   input  logic [ADDR_W-21:0]      isa_top,
   input  logic [ROM_SECTIONS-1:0] rom_en,
   output logic                    fwd
);
   localparam int KB       = 1024;
   localparam int SEC_SIZE = (128 * KB) / ROM_SECTIONS;
   localparam logic [ADDR_W-1:0] B512 = ADDR_W'(512 * KB);
   localparam logic [ADDR_W-1:0] B640 = ADDR_W'(640 * KB);
   localparam logic [ADDR_W-1:0] B768 = ADDR_W'(768 * KB);
   localparam logic [ADDR_W-1:0] B896 = ADDR_W'(896 * KB);
   localparam logic [ADDR_W-1:0] B960 = ADDR_W'(960 * KB);

   if (ADDR_W != 24) begin : g_bad_aw
      $error("ADDR_W must be 24 for the legacy map");
   end
   if (SEC_SIZE * ROM_SECTIONS != 128 * KB) begin : g_bad_sec
      $error("ROM_SECTIONS must divide the 128 KB window evenly");
   end

   logic [ROM_SECTIONS-1:0] rom_hit;
   for (genvar g = 0; g < ROM_SECTIONS; g++) begin : g_rom
      localparam logic [ADDR_W-1:0] SLO = ADDR_W'(768 * KB + g * SEC_SIZE);
      localparam logic [ADDR_W-1:0] SHI = ADDR_W'(768 * KB + (g + 1) * SEC_SIZE);
      assign rom_hit[g] = rom_en[g] && (addr >= SLO) && (addr < SHI);
   end

   logic [ADDR_W-21:0] mb;
   assign mb = addr[ADDR_W-1:20];

   always_comb begin
      if (mb != '0)          fwd = !(mb <= isa_top);
      else if (addr < B512)  fwd = low_en[0];
      else if (addr < B640)  fwd = low_en[1];
      else if (addr < B768)  fwd = low_en[2];
      else if (addr < B896)  fwd = |rom_hit;
      else if (addr < B960)  fwd = low_en[3];
      else                   fwd = 1'b1;
   end
endmodule

// File: rtl/ipb_strobe_sync.sv
`timescale 1ns/1ps
module ipb_strobe_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic memr_n,
   input  logic memw_n,
   output logic rd_act,
   output logic wr_act
);
   if (STAGES == 0) begin : g_direct
      assign rd_act = !memr_n;
      assign wr_act = !memw_n;
   end else begin : g_sync
      logic [STAGES-1:0] r_q, w_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r_q <= '1;
            w_q <= '1;
         end else begin
            r_q[0] <= memr_n;
            w_q[0] <= memw_n;
            for (int i = 1; i < STAGES; i++) begin
               r_q[i] <= r_q[i-1];
               w_q[i] <= w_q[i-1];
            end
         end
      end
      assign rd_act = !r_q[STAGES-1];
      assign wr_act = !w_q[STAGES-1];
   end
endmodule

// File: rtl/ipb_pci_master.sv
`timescale 1ns/1ps
module ipb_pci_master
   import ipb_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int ISA_DW      = 16,
   parameter int PCI_DW      = 32,
   parameter int ABORT_EDGES = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gnt,
   input  logic              rd_act,
   input  logic              wr_act,
   input  logic              fwd,
   input  logic [ADDR_W-1:0] addr,
   input  logic              sbhe_n,
   input  logic [ISA_DW-1:0] wdata,
   input  logic [PCI_DW-1:0] ad_in,
   input  logic              trdy_n,
   input  logic              devsel_n,
   output logic [PCI_DW-1:0] ad_out,
   output logic              ad_oe,
   output logic [3:0]        cbe_n,
   output logic              cbe_oe,
   output logic              par,
   output logic              par_oe,
   output logic              frame_n,
   output logic              irdy_n,
   output logic [ISA_DW-1:0] rdata,
   output logic              isa_rdy
);
   localparam int CNT_W = $clog2(ABORT_EDGES + 1);

   if (PCI_DW != 2 * ISA_DW) begin : g_bad_dw
      $error("PCI_DW must be twice ISA_DW");
   end
   if (ABORT_EDGES < 2) begin : g_bad_ab
      $error("ABORT_EDGES must be at least 2");
   end

   mst_state_e        st;
   logic [PCI_DW-1:0] ad_q;
   logic [3:0]        cbe_q, be_q;
   logic              ad_oe_q, cbe_oe_q, par_q, par_oe_q;
   logic              wr_q, hi_q, seen_q;
   logic [ISA_DW-1:0] wd_q;
   logic [CNT_W-1:0]  cnt_q;

   logic       stb, go;
   logic [1:0] be_pair;
   logic [3:0] be_lanes;

   assign stb      = rd_act | wr_act;
   assign go       = (st == ST_IDLE) && stb && fwd && gnt;
   assign be_pair  = {!sbhe_n, !addr[0]};
   assign be_lanes = addr[1] ? {be_pair, 2'b00} : {2'b00, be_pair};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         ad_q     <= '0;
         cbe_q    <= 4'hF;
         be_q     <= '0;
         ad_oe_q  <= 1'b0;
         cbe_oe_q <= 1'b0;
         par_q    <= 1'b0;
         par_oe_q <= 1'b0;
         frame_n  <= 1'b1;
         irdy_n   <= 1'b1;
         wr_q     <= 1'b0;
         hi_q     <= 1'b0;
         seen_q   <= 1'b0;
         wd_q     <= '0;
         cnt_q    <= '0;
         rdata    <= '0;
      end else begin
         par_q    <= ^{ad_q, cbe_q};
         par_oe_q <= ad_oe_q;
         unique case (st)
            ST_IDLE: begin
               if (go) begin
                  st       <= ST_APH;
                  frame_n  <= 1'b0;
                  ad_q     <= {{(PCI_DW-ADDR_W){1'b0}}, addr[ADDR_W-1:2], 2'b00};
                  cbe_q    <= wr_act ? CMD_MEM_WR : CMD_MEM_RD;
                  ad_oe_q  <= 1'b1;
                  cbe_oe_q <= 1'b1;
                  wr_q     <= wr_act;
                  hi_q     <= addr[1];
                  be_q     <= be_lanes;
                  wd_q     <= wdata;
               end
            end
            ST_APH: begin
               st      <= ST_DPH1;
               irdy_n  <= 1'b0;
               cbe_q   <= ~be_q;
               ad_oe_q <= wr_q;
               cnt_q   <= '0;
               seen_q  <= 1'b0;
               if (wr_q) ad_q <= hi_q ? {wd_q, {ISA_DW{1'b0}}} : {{ISA_DW{1'b0}}, wd_q};
            end
            ST_DPH1, ST_DPHW: begin
               frame_n <= 1'b1;
               cnt_q   <= cnt_q + 1'b1;
               if (!devsel_n) seen_q <= 1'b1;
               if (!trdy_n || (devsel_n && !seen_q && cnt_q == CNT_W'(ABORT_EDGES - 1))) begin
                  st       <= ST_HOLD;
                  irdy_n   <= 1'b1;
                  ad_oe_q  <= 1'b0;
                  cbe_oe_q <= 1'b0;
                  if (!wr_q) rdata <= !trdy_n ? (hi_q ? ad_in[PCI_DW-1:ISA_DW] : ad_in[ISA_DW-1:0])
                                              : '1;
               end else begin
                  st <= ST_DPHW;
               end
            end
            ST_HOLD: if (!stb) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign ad_out  = ad_q;
   assign cbe_n   = cbe_q;
   assign par     = par_q;
   assign ad_oe   = ad_oe_q & gnt;
   assign cbe_oe  = cbe_oe_q & gnt;
   assign par_oe  = par_oe_q & gnt;
   assign isa_rdy = !(stb && fwd && st != ST_HOLD);
endmodule

// File: rtl/isa_pci_membridge.sv
`timescale 1ns/1ps
module isa_pci_membridge #(
   parameter int ADDR_W       = 24,
   parameter int ISA_DW       = 16,
   parameter int PCI_DW       = 32,
   parameter int ROM_SECTIONS = 8,
   parameter int ABORT_EDGES  = 5,
   parameter int SYNC_STAGES  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [7:0]        cfg_wdata,
   input  logic              isa_memr_n,
   input  logic              isa_memw_n,
   input  logic              isa_sbhe_n,
   input  logic [ADDR_W-1:0] isa_addr,
   input  logic [ISA_DW-1:0] isa_wdata,
   output logic [ISA_DW-1:0] isa_rdata,
   output logic              isa_rdy,
   input  logic              pci_gnt,
   output logic [PCI_DW-1:0] pci_ad_out,
   input  logic [PCI_DW-1:0] pci_ad_in,
   output logic              pci_ad_oe,
   output logic [3:0]        pci_cbe_n,
   output logic              pci_cbe_oe,
   output logic              pci_par,
   output logic              pci_par_oe,
   output logic              pci_frame_n,
   output logic              pci_irdy_n,
   input  logic              pci_trdy_n,
   input  logic              pci_devsel_n
);
   localparam int TOP_W = ADDR_W - 20;

   logic [3:0]              low_en;
   logic [TOP_W-1:0]        isa_top;
   logic [ROM_SECTIONS-1:0] rom_en;
   logic                    fwd, rd_act, wr_act;

   ipb_cfg_bank #(.ROM_SECTIONS(ROM_SECTIONS), .TOP_W(TOP_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .low_en(low_en), .isa_top(isa_top), .rom_en(rom_en)
   );

   ipb_region_dec #(.ADDR_W(ADDR_W), .ROM_SECTIONS(ROM_SECTIONS)) u_dec (
      .addr(isa_addr), .low_en(low_en), .isa_top(isa_top), .rom_en(rom_en), .fwd(fwd)
   );

   ipb_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .memr_n(isa_memr_n), .memw_n(isa_memw_n),
      .rd_act(rd_act), .wr_act(wr_act)
   );

   ipb_pci_master #(
      .ADDR_W(ADDR_W), .ISA_DW(ISA_DW), .PCI_DW(PCI_DW), .ABORT_EDGES(ABORT_EDGES)
   ) u_mst (
      .clk(clk), .rst_n(rst_n), .gnt(pci_gnt), .rd_act(rd_act), .wr_act(wr_act),
      .fwd(fwd), .addr(isa_addr), .sbhe_n(isa_sbhe_n), .wdata(isa_wdata),
      .ad_in(pci_ad_in), .trdy_n(pci_trdy_n), .devsel_n(pci_devsel_n),
      .ad_out(pci_ad_out), .ad_oe(pci_ad_oe), .cbe_n(pci_cbe_n), .cbe_oe(pci_cbe_oe),
      .par(pci_par), .par_oe(pci_par_oe), .frame_n(pci_frame_n), .irdy_n(pci_irdy_n),
      .rdata(isa_rdata), .isa_rdy(isa_rdy)
   );
endmodule

// File: rtl/ipb_checker.sv
`timescale 1ns/1ps
module ipb_checker #(
   parameter int PCI_DW = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              isa_memr_n,
   input logic              isa_memw_n,
   input logic              isa_rdy,
   input logic              pci_gnt,
   input logic [PCI_DW-1:0] pci_ad_out,
   input logic [3:0]        pci_cbe_n,
   input logic              pci_cbe_oe,
   input logic              pci_par,
   input logic              pci_par_oe,
   input logic              pci_frame_n,
   input logic              pci_irdy_n
);
   assert_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pci_frame_n) |-> pci_cbe_oe && (pci_cbe_n == 4'b0110 || pci_cbe_n == 4'b0111));

   assert_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pci_frame_n) |-> $past(!isa_memr_n || !isa_memw_n));

   assert_frame_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pci_frame_n) |=> !pci_frame_n);

   assert_frame_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pci_frame_n && $past(!pci_frame_n)) |=> pci_frame_n);

   assert_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pci_par_oe |-> (pci_par == ^$past({pci_ad_out, pci_cbe_n})));

   assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pci_irdy_n) |-> isa_rdy);

   assert_grant_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pci_frame_n) |-> $past(pci_gnt));
endmodule

bind isa_pci_membridge ipb_checker #(.PCI_DW(PCI_DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .isa_memr_n(isa_memr_n), .isa_memw_n(isa_memw_n),
   .isa_rdy(isa_rdy), .pci_gnt(pci_gnt), .pci_ad_out(pci_ad_out), .pci_cbe_n(pci_cbe_n),
   .pci_cbe_oe(pci_cbe_oe), .pci_par(pci_par), .pci_par_oe(pci_par_oe),
   .pci_frame_n(pci_frame_n), .pci_irdy_n(pci_irdy_n)
);

// File: tb/isa_pci_membridge_bench.sv
`timescale 1ns/1ps
module isa_pci_membridge_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        isa_memr_n = 1'b1, isa_memw_n = 1'b1, isa_sbhe_n = 1'b1;
   logic [23:0] isa_addr = '0;
   logic [15:0] isa_wdata = '0;
   logic [15:0] isa_rdata;
   logic        isa_rdy;
   logic        pci_gnt = 1'b1;
   logic [31:0] pci_ad_out, pci_ad_in = '0;
   logic        pci_ad_oe, pci_cbe_oe, pci_par, pci_par_oe, pci_frame_n, pci_irdy_n;
   logic [3:0]  pci_cbe_n;
   logic        pci_trdy_n = 1'b1, pci_devsel_n = 1'b1;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   isa_pci_membridge u_isa_pci_membridge (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .isa_memr_n(isa_memr_n), .isa_memw_n(isa_memw_n), .isa_sbhe_n(isa_sbhe_n),
      .isa_addr(isa_addr), .isa_wdata(isa_wdata), .isa_rdata(isa_rdata), .isa_rdy(isa_rdy),
      .pci_gnt(pci_gnt), .pci_ad_out(pci_ad_out), .pci_ad_in(pci_ad_in), .pci_ad_oe(pci_ad_oe),
      .pci_cbe_n(pci_cbe_n), .pci_cbe_oe(pci_cbe_oe), .pci_par(pci_par), .pci_par_oe(pci_par_oe),
      .pci_frame_n(pci_frame_n), .pci_irdy_n(pci_irdy_n), .pci_trdy_n(pci_trdy_n),
      .pci_devsel_n(pci_devsel_n)
   );

   typedef struct packed {
      logic [23:0] a;
      logic        wr;
      logic        sb;
      logic [15:0] wd;
      logic [2:0]  lat;
      logic        fwd;
      logic [31:0] tgt;
   } vec_t;

   // config: byte0=05h, byte1 top=3, byte2 ROM sections 0 and 5
   localparam vec_t VT [14] = '{
      '{24'h001234, 1'b0, 1'b0, 16'h0000, 3'd0, 1'b1, 32'hCAFE1234},
      '{24'h07FFFE, 1'b0, 1'b0, 16'h0000, 3'd1, 1'b1, 32'h0BAD5EED},
      '{24'h082346, 1'b1, 1'b0, 16'h1357, 3'd0, 1'b0, 32'h00000000},
      '{24'h0A0002, 1'b1, 1'b0, 16'hBEEF, 3'd2, 1'b1, 32'h00000000},
      '{24'h0BFFFE, 1'b0, 1'b0, 16'h0000, 3'd0, 1'b1, 32'hDEADBEEF},
      '{24'h0C0000, 1'b0, 1'b0, 16'h0000, 3'd1, 1'b1, 32'h11112222},
      '{24'h0C4000, 1'b0, 1'b0, 16'h0000, 3'd0, 1'b0, 32'h00000000},
      '{24'h0D4001, 1'b1, 1'b0, 16'hAB00, 3'd0, 1'b1, 32'h00000000},
      '{24'h0E0000, 1'b0, 1'b0, 16'h0000, 3'd0, 1'b0, 32'h00000000},
      '{24'h0F8002, 1'b0, 1'b0, 16'h0000, 3'd1, 1'b1, 32'h55AA0FF0},
      '{24'h100000, 1'b1, 1'b0, 16'h2468, 3'd0, 1'b0, 32'h00000000},
      '{24'h3FFFFE, 1'b0, 1'b0, 16'h0000, 3'd0, 1'b0, 32'h00000000},
      '{24'h400000, 1'b0, 1'b0, 16'h0000, 3'd3, 1'b1, 32'h87654321},
      '{24'hFFFFFC, 1'b1, 1'b0, 16'h0F0F, 3'd0, 1'b1, 32'h00000000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string region_req(input logic [23:0] a);
      if (a >= 24'h100000) return "R4";
      if (a >= 24'h0C0000 && a < 24'h0E0000) return "R3";
      return "R2";
   endfunction

   task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic release_isa();
      pci_devsel_n = 1'b1; pci_trdy_n = 1'b1;
      isa_memr_n = 1'b1; isa_memw_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run_cycle(input vec_t v);
      string rq;
      int    frames, w;
      logic [3:0]  be;
      logic [31:0] adr, dat;
      rq  = region_req(v.a);
      be  = v.a[1] ? {!v.sb, !v.a[0], 2'b00} : {2'b00, !v.sb, !v.a[0]};
      adr = {8'h00, v.a[23:2], 2'b00};
      dat = v.a[1] ? {v.wd, 16'h0000} : {16'h0000, v.wd};
      frames = 0;
      @(negedge clk);
      isa_addr = v.a; isa_sbhe_n = v.sb; isa_wdata = v.wd; pci_ad_in = v.tgt;
      if (v.wr) isa_memw_n = 1'b0; else isa_memr_n = 1'b0;
      #1 chk({rq, "/R10 rdy at strobe"}, {31'd0, isa_rdy}, {31'd0, !v.fwd});
      @(negedge clk);
      if (!v.fwd) begin
         chk({rq, "/R5 frame"}, {31'd0, pci_frame_n}, 32'd1);
         chk("R5 rdy", {31'd0, isa_rdy}, 32'd1);
      end else begin
         frames += !pci_frame_n;
         chk({rq, "/R6 frame"}, {31'd0, pci_frame_n}, 32'd0);
         chk("R6 ad", pci_ad_out, adr);
         chk("R6 cmd", {28'd0, pci_cbe_n}, v.wr ? 32'd7 : 32'd6);
         chk("R6 oe", {30'd0, pci_ad_oe, pci_cbe_oe}, 32'd3);
         @(negedge clk);
         frames += !pci_frame_n;
         chk("R7 irdy", {31'd0, pci_irdy_n}, 32'd0);
         chk("R8 be", {28'd0, pci_cbe_n}, {28'd0, ~be});
         chk("R8 ad_oe", {31'd0, pci_ad_oe}, {31'd0, v.wr});
         if (v.wr) chk("R8 wdata", pci_ad_out, dat);
         chk("R9 par_oe", {31'd0, pci_par_oe}, 32'd1);
         chk("R9 par", {31'd0, pci_par}, {31'd0, ^{adr, (v.wr ? 4'b0111 : 4'b0110)}});
         pci_devsel_n = 1'b0;
         w = int'(v.lat);
         pci_trdy_n = (w == 0) ? 1'b0 : 1'b1;
         forever begin
            @(negedge clk);
            frames += !pci_frame_n;
            if (w == 0) break;
            chk("R10 stretch", {31'd0, isa_rdy}, 32'd0);
            w--;
            pci_trdy_n = (w == 0) ? 1'b0 : 1'b1;
         end
         chk("R7 frame count", frames, 32'd2);
         chk("R7 irdy end", {31'd0, pci_irdy_n}, 32'd1);
         chk("R10 rdy end", {31'd0, isa_rdy}, 32'd1);
         if (!v.wr) chk("R10 rdata", {16'd0, isa_rdata},
                        {16'd0, (v.a[1] ? v.tgt[31:16] : v.tgt[15:0])});
      end
      release_isa();
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (all requirements) actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 frame", {31'd0, pci_frame_n}, 32'd1);
      chk("R1 irdy", {31'd0, pci_irdy_n}, 32'd1);
      chk("R1 oe", {29'd0, pci_ad_oe, pci_cbe_oe, pci_par_oe}, 32'd0);
      chk("R1 rdy", {31'd0, isa_rdy}, 32'd1);
      rst_n = 1'b1;
      cfg_write(2'd0, 8'h05);
      cfg_write(2'd1, 8'h03);
      cfg_write(2'd2, 8'h21);

      for (int i = 0; i < 14; i++) run_cycle(VT[i]);

      // R4 with T=0: 1 MB forwarded; R3 with section 5 disabled
      cfg_write(2'd1, 8'h00);
      cfg_write(2'd2, 8'h01);
      run_cycle('{24'h100000, 1'b1, 1'b0, 16'h2468, 3'd0, 1'b1, 32'h0});
      run_cycle('{24'h0D4001, 1'b1, 1'b0, 16'hAB00, 3'd0, 1'b0, 32'h0});

      // R11 master abort: no DEVSEL at any of five edges
      @(negedge clk);
      isa_addr = 24'h400010; isa_sbhe_n = 1'b0; pci_ad_in = 32'h12345678; isa_memr_n = 1'b0;
      repeat (6) @(negedge clk);
      chk("R11 irdy before fifth edge", {31'd0, pci_irdy_n}, 32'd0);
      chk("R11 rdy before fifth edge", {31'd0, isa_rdy}, 32'd0);
      @(negedge clk);
      chk("R11 irdy after abort", {31'd0, pci_irdy_n}, 32'd1);
      chk("R11 rdy after abort", {31'd0, isa_rdy}, 32'd1);
      chk("R11 rdata ones", {16'd0, isa_rdata}, 32'h0000FFFF);
      release_isa();

      // R11 DEVSEL exactly at fifth edge prevents abort
      @(negedge clk);
      isa_addr = 24'h400000; pci_ad_in = 32'hA5A5C3C3; isa_memr_n = 1'b0;
      repeat (6) @(negedge clk);
      pci_devsel_n = 1'b0;
      @(negedge clk);
      chk("R11 late devsel irdy", {31'd0, pci_irdy_n}, 32'd0);
      pci_trdy_n = 1'b0;
      @(negedge clk);
      chk("R11 late devsel rdy", {31'd0, isa_rdy}, 32'd1);
      chk("R11 late devsel rdata", {16'd0, isa_rdata}, 32'h0000C3C3);
      release_isa();

      // R12 no grant
      pci_gnt = 1'b0;
      @(negedge clk);
      isa_addr = 24'h400000; isa_wdata = 16'h7777; isa_memw_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R12 no frame", {31'd0, pci_frame_n}, 32'd1);
      chk("R12 no drive", {31'd0, pci_ad_oe}, 32'd0);
      chk("R12 rdy held", {31'd0, isa_rdy}, 32'd0);
      pci_gnt = 1'b1;
      @(negedge clk);
      chk("R12 start after grant", {31'd0, pci_frame_n}, 32'd0);
      @(negedge clk);
      pci_gnt = 1'b0;
      #1 chk("R12 drop grant", {30'd0, pci_ad_oe, pci_cbe_oe}, 32'd0);
      pci_gnt = 1'b1;
      pci_devsel_n = 1'b0; pci_trdy_n = 1'b0;
      @(negedge clk);
      chk("R12 completes", {31'd0, isa_rdy}, 32'd1);
      release_isa();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule